// File: doc/BRIEF.md
# Serial EEPROM Burst Read Controller

This block is a bus master that fetches a run of consecutive 16-bit words from a three-wire-plus-select serial EEPROM (Microwire style). A single start strobe carries a first word address and a word count. The controller first asks an arbiter for the shared memory port and waits for a grant. If the grant does not arrive in time, it gives up and reports an error. Once it holds the port, it runs one complete READ transaction per word. Each word appears on a parallel output with a one-cycle valid strobe. A done pulse closes the burst.

For every word, chip select is raised and one idle serial clock is sent with data in held low. The block then sends the start bit and READ opcode (1, 1, 0), followed by the word address. After that it clocks 17 read cycles. The first bit returned is the part's leading zero and is discarded. Between words, chip select is dropped and a fixed number of extra serial clocks are sent. The serial clock high and low times are counted in system clock cycles, so the minimum timings of the part can be met at any system clock rate.

The state machine has six states:
- ST_IDLE goes to ST_ACQUIRE on an accepted start.
- ST_ACQUIRE goes to ST_SELECT on grant, or back to ST_IDLE on timeout.
- ST_SELECT goes to ST_SEND after its one bit.
- ST_SEND goes to ST_RECV after 3+ADDR_W bits.
- ST_RECV goes to ST_GAP after DATA_W+1 bits.
- ST_GAP goes to ST_SELECT when words remain, or to ST_IDLE after the last word.

Top module: `eeprom_burst_reader`

## Requirements
- R1: A start with a nonzero count raises `port_req_o` one cycle later. `ee_cs_o` is never high unless `port_req_o` is high, and no serial activity begins before `port_gnt_i` has been seen.
- R2: If no grant arrives, `port_req_o` stays high for exactly TIMEOUT_CYC cycles and then drops. In the same cycle that it drops, `done_o` pulses and `err_o` rises. No chip select is issued. `err_o` holds until the next accepted start.
- R3: Each word transaction raises `ee_cs_o` with exactly one leading serial clock at `ee_di_o`=0. The start bit 1 follows, then opcode bits 1,0, then the ADDR_W-bit word address, most significant bit first.
- R4: `ee_do_i` is sampled at each of 17 rising serial clock edges in the read phase. The first sample is discarded and the remaining 16 form the word, most significant bit first.
- R5: Words are read from addresses start, start+1, …, start+count-1, wrapping modulo 2^ADDR_W. There is one full command per word. After every word, `ee_cs_o` is low for exactly GAP_CLKS rising serial clocks.
- R6: `ee_sk_o` stays high for at least HI_CYC cycles and low for at least LO_CYC cycles. `ee_cs_o` and `ee_di_o` change only while `ee_sk_o` is low.
- R7: Each word produces one single-cycle `word_valid_o` pulse with `word_data_o` valid in that cycle. There are exactly count pulses per burst.
- R8: After the last word, `done_o` pulses for one cycle. `port_req_o` is low in that cycle and `err_o` is 0.
- R9: A start with count 0 gives a `done_o` pulse one cycle later with no port request and no serial activity.
- R10: A start strobe while a burst is in progress is ignored. The running burst's addresses, data and word count are unchanged.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Burst start strobe, taken only when idle |
| start_addr_i | input | ADDR_W | First word address |
| word_cnt_i | input | ADDR_W+1 | Number of words to read |
| port_req_o | output | 1 | Shared memory port request |
| port_gnt_i | input | 1 | Shared memory port grant |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_data_o | output | DATA_W | Word read, valid with the strobe |
| done_o | output | 1 | One-cycle end-of-burst pulse |
| err_o | output | 1 | Grant timeout flag |

## Verification
The request is due one cycle after the start strobe. A count-zero done is also due one cycle after the strobe. On a timeout, the request falls exactly TIMEOUT_CYC cycles after it rose, and the done pulse and error flag appear in that same cycle. A completed burst likewise drops the request in the cycle of its done pulse. A word strobe arrives at the end of the high phase of the 17th read clock, and the bench samples every output on the falling system clock edge so that registered results are settled. A behavioural EEPROM model in the bench decodes the command and address on each rising serial clock. It also drives the leading zero and the data bits and counts the gap clocks. Each word is then compared with a value computed from its expected address.

// File: rtl/eebr_pkg.sv
package eebr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_SELECT,
        ST_SEND,
        ST_RECV,
        ST_GAP
    } eebr_state_e;

    // start bit followed by the read opcode, sent first bit leftmost
    localparam int unsigned CMD_BITS = 3;
    localparam logic [CMD_BITS-1:0] READ_CMD = 3'b110;
endpackage

// File: rtl/eebr_timer.sv
module eebr_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/eebr_cmd_shift.sv
module eebr_cmd_shift #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], 1'b0};
        end
    end

    assign msb = sr_q[W-1];
endmodule

// File: rtl/eebr_rx_shift.sv
module eebr_rx_shift #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sample) begin
            sr_q <= {sr_q[W-2:0], bit_in};
        end
    end

    assign word = sr_q;
endmodule

// File: rtl/eeprom_burst_reader.sv
module eeprom_burst_reader
    import eebr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned HI_CYC      = 150,
    parameter int unsigned LO_CYC      = 50,
    parameter int unsigned GAP_CLKS    = 2,
    parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W:0]   word_cnt_i,
    output logic              port_req_o,
    input  logic              port_gnt_i,
    output logic              ee_cs_o,
    output logic              ee_sk_o,
    output logic              ee_di_o,
    input  logic              ee_do_i,
    output logic              word_valid_o,
    output logic [DATA_W-1:0] word_data_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int unsigned CNT_W     = ADDR_W + 1;
    localparam int unsigned SEND_BITS = CMD_BITS + ADDR_W;
    localparam int unsigned RECV_BITS = DATA_W + 1;
    localparam int unsigned PH_MAX    = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int unsigned PH_W      = $clog2(PH_MAX + 1);
    localparam int unsigned TO_W      = $clog2(TIMEOUT_CYC + 1);
    localparam int unsigned BIT_W     = $clog2(SEND_BITS + RECV_BITS + GAP_CLKS + 1);

    eebr_state_e state_q, state_d;

    logic              sk_q, req_q, valid_q, done_q, err_q;
    logic [ADDR_W-1:0] addr_q, cmd_addr;
    logic [CNT_W-1:0]  left_q;
    logic [BIT_W-1:0]  bit_q, bits_now;

    logic in_bits, ph_zero, to_zero, last_bit;
    logic accept, zero_req, grant_ev, timeout_ev;
    logic rise_ev, bit_end, word_end, gap_end, burst_end, enter_sel;
    logic ph_load, cmd_msb;
    logic [PH_W-1:0] ph_val;

    // ---------------- event decode ----------------
    always_comb begin
        in_bits = (state_q == ST_SELECT) || (state_q == ST_SEND) ||
                  (state_q == ST_RECV)   || (state_q == ST_GAP);
        unique case (state_q)
            ST_SEND: bits_now = BIT_W'(SEND_BITS);
            ST_RECV: bits_now = BIT_W'(RECV_BITS);
            ST_GAP:  bits_now = BIT_W'(GAP_CLKS);
            default: bits_now = BIT_W'(1);
        endcase
        last_bit   = (bit_q == bits_now - 1'b1);
        accept     = (state_q == ST_IDLE) && start_i && (word_cnt_i != '0);
        zero_req   = (state_q == ST_IDLE) && start_i && (word_cnt_i == '0);
        grant_ev   = (state_q == ST_ACQUIRE) && port_gnt_i;
        timeout_ev = (state_q == ST_ACQUIRE) && !port_gnt_i && to_zero;
        rise_ev    = in_bits && !sk_q && ph_zero;
        bit_end    = in_bits && sk_q && ph_zero;
        word_end   = (state_q == ST_RECV) && bit_end && last_bit;
        gap_end    = (state_q == ST_GAP) && bit_end && last_bit;
        burst_end  = gap_end && (left_q == CNT_W'(1));
        enter_sel  = grant_ev || (gap_end && !burst_end);
        ph_load    = grant_ev || (in_bits && ph_zero);
        ph_val     = rise_ev ? PH_W'(HI_CYC - 1) : PH_W'(LO_CYC - 1);
        cmd_addr   = grant_ev ? addr_q : addr_q + 1'b1;
    end

    // ---------------- sub-blocks ----------------
    eebr_timer #(.W(PH_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    eebr_timer #(.W(TO_W)) u_grant_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (TO_W'(TIMEOUT_CYC - 1)),
        .zero     (to_zero)
    );

    eebr_cmd_shift #(.W(SEND_BITS)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter_sel),
        .load_val ({READ_CMD, cmd_addr}),
        .shift    ((state_q == ST_SEND) && bit_end),
        .msb      (cmd_msb)
    );

    eebr_rx_shift #(.W(DATA_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample ((state_q == ST_RECV) && rise_ev),
        .bit_in (ee_do_i),
        .word   (word_data_o)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_ACQUIRE;
            ST_ACQUIRE: begin
                if (port_gnt_i)   state_d = ST_SELECT;
                else if (to_zero) state_d = ST_IDLE;
            end
            ST_SELECT:  if (bit_end) state_d = ST_SEND;
            ST_SEND:    if (bit_end && last_bit) state_d = ST_RECV;
            ST_RECV:    if (bit_end && last_bit) state_d = ST_GAP;
            ST_GAP:     if (gap_end) state_d = burst_end ? ST_IDLE : ST_SELECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- output and datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_q    <= 1'b0;
            req_q   <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            left_q  <= '0;
            bit_q   <= '0;
        end else begin
            valid_q <= word_end;
            done_q  <= zero_req || timeout_ev || burst_end;
            if (accept) begin
                req_q  <= 1'b1;
                err_q  <= 1'b0;
                addr_q <= start_addr_i;
                left_q <= word_cnt_i;
            end
            if (zero_req) err_q <= 1'b0;
            if (timeout_ev) begin
                req_q <= 1'b0;
                err_q <= 1'b1;
            end
            if (grant_ev) begin
                sk_q  <= 1'b0;
                bit_q <= '0;
            end
            if (in_bits && ph_zero) sk_q <= !sk_q;
            if (bit_end) bit_q <= last_bit ? '0 : bit_q + 1'b1;
            if (gap_end) begin
                left_q <= left_q - 1'b1;
                addr_q <= addr_q + 1'b1;
                if (burst_end) req_q <= 1'b0;
            end
        end
    end

    assign port_req_o   = req_q;
    assign ee_cs_o      = (state_q == ST_SELECT) || (state_q == ST_SEND) || (state_q == ST_RECV);
    assign ee_sk_o      = sk_q;
    assign ee_di_o      = (state_q == ST_SEND) && cmd_msb;
    assign word_valid_o = valid_q;
    assign done_o       = done_q;
    assign err_o        = err_q;
endmodule

// File: rtl/eebr_checker.sv
module eebr_checker #(
    parameter int unsigned HI_CYC = 150,
    parameter int unsigned LO_CYC = 50
) (
    input logic clk,
    input logic rst_n,
    input logic port_req_o,
    input logic ee_cs_o,
    input logic ee_sk_o,
    input logic ee_di_o,
    input logic word_valid_o,
    input logic done_o
);
    logic [15:0] hi_run, lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= ee_sk_o ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= ee_sk_o ? '0 : ((lo_run == 16'hFFFF) ? lo_run : lo_run + 1'b1);
        end
    end

    AST_CS_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ee_cs_o |-> port_req_o); // R1
    AST_SK_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_sk_o) |-> (hi_run >= 16'(HI_CYC))); // R6
    AST_SK_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_sk_o) |-> (lo_run >= 16'(LO_CYC))); // R6
    AST_CS_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_cs_o)); // R6
    AST_DI_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk_o && $past(ee_sk_o)) |-> $stable(ee_di_o)); // R6
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |=> !word_valid_o); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_RELEASES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !port_req_o); // R8
endmodule

bind eeprom_burst_reader eebr_checker #(.HI_CYC(HI_CYC), .LO_CYC(LO_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_req_o   (port_req_o),
    .ee_cs_o      (ee_cs_o),
    .ee_sk_o      (ee_sk_o),
    .ee_di_o      (ee_di_o),
    .word_valid_o (word_valid_o),
    .done_o       (done_o)
);

// File: tb/tb_eeprom_burst_reader.sv
`timescale 1ns/1ps
module tb_eeprom_burst_reader;
    localparam int HI = 3, LO = 2, GAP = 2, TMO = 100;

    logic clk = 0, rst_n = 0;
    logic start = 0, gnt = 0, ee_do = 0;
    logic [5:0] start_addr = 0;
    logic [6:0] word_cnt = 0;
    logic req, cs, sk, di, wvalid, done, err;
    logic [15:0] wdata;

    always #2.5 clk = ~clk;

    eeprom_burst_reader #(.ADDR_W(6), .DATA_W(16), .HI_CYC(HI), .LO_CYC(LO),
                          .GAP_CLKS(GAP), .TIMEOUT_CYC(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
        .word_cnt_i(word_cnt), .port_req_o(req), .port_gnt_i(gnt),
        .ee_cs_o(cs), .ee_sk_o(sk), .ee_di_o(di), .ee_do_i(ee_do),
        .word_valid_o(wvalid), .word_data_o(wdata), .done_o(done), .err_o(err));

    int checks = 0, failures = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ee_word(input logic [5:0] a);
        return {a, ~a, a[3:0]} ^ 16'hC3A5;
    endfunction

    // ---------------- grant driver ----------------
    int gdelay = 0, gcnt = 0;
    always @(negedge clk) begin
        if (!req) begin gcnt = 0; gnt = 0; end
        else begin
            if (gcnt >= gdelay) gnt = 1;
            gcnt++;
        end
    end

    // ---------------- EEPROM model ----------------
    logic [5:0] exp_base = 0;
    int m_idx = 0, m_lead = 0, m_nbits = 0, m_rbit = 0, gap_clks = 0;
    bit m_started = 0, m_reading = 0;
    logic [7:0] m_sr = 0;
    logic [15:0] m_word = 0;

    always @(posedge cs) begin
        if (m_idx > 0) chk(gap_clks == GAP, "R5 gap clocks between words", gap_clks, GAP);
        gap_clks = 0; m_lead = 0;
    end
    always @(negedge cs) begin
        m_started = 0; m_reading = 0; ee_do = 0;
    end
    always @(posedge sk) begin
        if (!cs) gap_clks++;
        else if (m_reading) begin
            ee_do = m_word[m_rbit];
            if (m_rbit > 0) m_rbit--;
        end else if (!m_started) begin
            if (di) begin m_started = 1; m_nbits = 0; m_sr = 0; end
            else m_lead++;
        end else begin
            m_sr = {m_sr[6:0], di};
            m_nbits++;
            if (m_nbits == 8) begin
                chk(m_lead == 1, "R3 one leading clock with di low", m_lead, 1);
                chk(m_sr[7:6] == 2'b10, "R3 read opcode", m_sr[7:6], 2'b10);
                chk(m_sr[5:0] == 6'(exp_base + m_idx), "R5 word address", m_sr[5:0], 6'(exp_base + m_idx));
                m_word = ee_word(m_sr[5:0]);
                m_rbit = 15; m_reading = 1; ee_do = 0;
                m_idx++;
            end
        end
    end

    // ---------------- output monitors ----------------
    int w_idx = 0, req_cyc = 0, run = 0, min_hi = 9999, min_lo = 9999;
    bit cs_seen = 0, prev_sk = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (wvalid) begin
                chk(wdata == ee_word(6'(exp_base + w_idx)), "R4 word data",
                    wdata, ee_word(6'(exp_base + w_idx)));
                w_idx++;
            end
            if (req) req_cyc++;
            if (cs) cs_seen = 1;
            if (sk != prev_sk) begin
                if (prev_sk && run < min_hi) min_hi = run;
                if (!prev_sk && run < min_lo && cyc > 20) min_lo = run;
                run = 1;
            end else run++;
            prev_sk = sk;
        end
        if (cyc == 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_done(output bit got);
        got = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
    endtask

    task automatic burst(input logic [5:0] a, input int n, input int gd, input bit inject);
        bit got;
        exp_base = a; w_idx = 0; m_idx = 0; gap_clks = 0; cs_seen = 0; req_cyc = 0;
        gdelay = gd;
        @(negedge clk); start = 1; start_addr = a; word_cnt = 7'(n);
        @(negedge clk); start = 0;
        chk(req == 1, "R1 request one cycle after start", req, 1);
        if (inject) begin
            repeat (30) @(negedge clk);
            start = 1; start_addr = a ^ 6'd21; word_cnt = 7'd3;
            @(negedge clk); start = 0;
        end
        wait_done(got);
        chk(got, "R8 done pulse", got, 1);
        chk(req == 0, "R8 request low at done", req, 0);
        chk(err == 0, "R8 no error at done", err, 0);
        chk(w_idx == n, "R7 word strobes per burst", w_idx, n);
        chk(m_idx == n, "R5 commands per burst", m_idx, n);
        chk(gap_clks == GAP, "R5 gap clocks after last word", gap_clks, GAP);
        repeat (5) @(negedge clk);
        chk(w_idx == n && !cs, "R10 no extra activity after burst", w_idx, n);
    endtask

    initial begin
        bit got;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk({req, cs, sk, di, wvalid, done, err} == 7'b0, "R11 outputs in reset",
            {req, cs, sk, di, wvalid, done, err}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({req, cs, sk, di, wvalid, done, err} == 7'b0, "R11 outputs after reset",
            {req, cs, sk, di, wvalid, done, err}, 0);

        // R9: count zero
        req_cyc = 0; cs_seen = 0;
        start = 1; start_addr = 6'd9; word_cnt = 0;
        @(negedge clk); start = 0;
        chk(done == 1, "R9 done one cycle after zero-count start", done, 1);
        chk(req == 0, "R9 no request for zero count", req, 0);
        repeat (4) @(negedge clk);
        chk(req_cyc == 0 && !cs_seen, "R9 no port or serial activity", req_cyc, 0);

        // R2: grant timeout
        gdelay = 1_000_000; req_cyc = 0; cs_seen = 0; w_idx = 0;
        start = 1; start_addr = 6'd4; word_cnt = 7'd2;
        @(negedge clk); start = 0;
        wait_done(got);
        chk(got && err == 1, "R2 error flag with done on timeout", err, 1);
        chk(req == 0, "R2 request dropped on timeout", req, 0);
        chk(req_cyc == TMO, "R2 request held for timeout", req_cyc, TMO);
        chk(!cs_seen && w_idx == 0, "R2 no select after timeout", cs_seen, 0);
        repeat (10) @(negedge clk);
        chk(err == 1, "R2 error flag holds until next start", err, 1);

        // directed bursts
        burst(6'd0, 1, 0, 0);
        burst(6'd62, 4, 3, 0);           // R5 wrap past top address
        burst(6'd17, 3, 5, 1);           // R10 start while busy
        burst(6'd63, 1, 0, 0);

        // random bursts
        for (int k = 0; k < 8; k++) begin
            burst(6'($urandom_range(63)), int'($urandom_range(1, 5)), int'($urandom_range(20)), 1'b0);
        end

        chk(min_hi >= HI, "R6 serial clock high time", min_hi, HI);
        chk(min_lo >= LO, "R6 serial clock low time", min_lo, LO);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule